// File: doc/BRIEF.md
# Per-Flow Traffic Accounting Counter Table

This block keeps a packet counter and a byte counter for every entry of a flow table whose traffic is forwarded in hardware. The forwarding path reports each frame on a count port. The report carries a flow index, the frame length in bytes and the flow's second info word. Bit 15 of that info word says whether the flow is accounted at all. Each accepted report adds the length to the entry's 48-bit byte counter and one to its 40-bit packet counter. Both counters stop at their maximum value instead of wrapping.

Software reaches the counters through a small register bus. A config register turns accounting on and selects whether a read clears the entry it returns. Counters are read indirectly. Software writes an entry index together with a start flag to a command register, then polls until the flag drops. It then collects the two counters from three result words in which the fields are split across word boundaries. With clear-on-read, each read returns only the traffic since the previous read, so software keeps the running totals itself.

Top module: `flow_acct_table`

## Requirements
- R1: After reset, every counter is zero, the busy flag is 0, and the config, command and result registers all read 0.
- R2: While accounting is enabled (config bit 0), a count report with info bit 15 set adds its length to the entry's byte counter and one to its packet counter. This holds for reports on consecutive cycles, including back-to-back reports to the same entry.
- R3: A report whose info bit 15 is clear is dropped, and so is any report that arrives while config bit 0 is 0. The entry keeps its old value.
- R4: Writing the command register (offset 0x33C) with bit 16 set and the index in bits 13:0 raises busy (bit 16 of a command read). A command read issued in the very next cycle returns busy 1, and busy is low again one cycle later.
- R5: Result word 0 (0x340) holds byte bits 31:0. Result word 1 (0x344) holds byte bits 47:32 in bits 15:0 and packet bits 15:0 in bits 31:16. Result word 2 (0x348) holds packet bits 39:16 in bits 23:0, and its other bits are 0.
- R6: With the read-clear bit (config bit 1) at 0, an indirect read leaves the entry unchanged, so two reads return the same counts.
- R7: With config bit 1 set, a completed read zeroes the entry it returned.
- R8: If a counted report and a clearing read reach the same entry in the same cycle, the read returns the counts from before that report. The entry is then left holding exactly that report's length and one packet.
- R9: A read of an index at or beyond the table depth returns all zeros. A report to such an index changes no entry.
- R10: The byte and packet counters saturate at all ones rather than wrapping.
- R11: A command write made while busy is set is ignored. The read in progress completes with its own index and result.
- R12: The config register is at offset 0x330. Bit 0 enables accounting, bit 1 selects read-clear, and both read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_valid | input | 1 | A count report is present this cycle |
| cnt_flow | input | 14 | Flow table index of the report |
| cnt_len | input | LEN_W | Frame length in bytes |
| cnt_info | input | 32 | Second info word of the flow; bit 15 enables counting |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |

## Verification
Several report patterns are used, and each one separates a different fault:
- Back-to-back reports interleaved between two entries show whether an update is lost or read stale.
- Reports with the count flag clear, reports while accounting is disabled, and reports just past the table depth show whether a filter or the index range check is missing.
- A long run of large frames to one entry pushes the byte count above 32 bits and the packet count above 16 bits, which exposes a wrong field split in the result words.
- A small-width instance driven past its limits tells saturation apart from wrapping.

Reads are issued with read-clear off and then on. A report and a clearing read are also made to collide on the same entry. A second command is written while busy, to show it is ignored.

// File: rtl/flow_acct_pkg.sv
package flow_acct_pkg;

  localparam int ADDR_W = 12;
  localparam int FIDX_W = 14;

  localparam logic [ADDR_W-1:0] OFS_CFG  = 12'h330;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 12'h33C;
  localparam logic [ADDR_W-1:0] OFS_RES0 = 12'h340;
  localparam logic [ADDR_W-1:0] OFS_RES1 = 12'h344;
  localparam logic [ADDR_W-1:0] OFS_RES2 = 12'h348;

  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_RCLR_BIT = 1;
  localparam int CMD_GO_BIT   = 16;
  localparam int INFO_CNT_BIT = 15;

  localparam int BYTE_FIELD_W = 48;
  localparam int PKT_FIELD_W  = 40;

  typedef struct packed {
    logic [31:0] w2;
    logic [31:0] w1;
    logic [31:0] w0;
  } res_words_t;

  // Spread a byte/packet count pair over the three result words.
  function automatic res_words_t pack_result(input logic [BYTE_FIELD_W-1:0] b,
                                             input logic [PKT_FIELD_W-1:0]  p);
    res_words_t r;
    r.w0 = b[31:0];
    r.w1 = {p[15:0], b[47:32]};
    r.w2 = {8'h00, p[39:16]};
    return r;
  endfunction

endpackage

// File: rtl/flow_acct_ingress.sv
// Registers the count port and drops reports that must not be counted.
module flow_acct_ingress
  import flow_acct_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              in_valid,
  input  logic [FIDX_W-1:0] in_flow,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [31:0]       in_info,
  output logic              upd_v,
  output logic [FIDX_W-1:0] upd_flow,
  output logic [LEN_W-1:0]  upd_len
);

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_v    <= 1'b0;
      upd_flow <= '0;
      upd_len  <= '0;
    end else begin
      upd_v    <= in_valid & cfg_en & in_info[INFO_CNT_BIT];
      upd_flow <= in_flow;
      upd_len  <= in_len;
    end
  end

  // R3: nothing passes while accounting is off
  a_r3_disabled_drop: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> !upd_v);

  // R3: a flow without its count flag never reaches the table
  a_r3_flag_drop: assert property (@(posedge clk) disable iff (rst)
    !in_info[INFO_CNT_BIT] |=> !upd_v);

endmodule

// File: rtl/flow_acct_store.sv
// Counter storage with saturating read-modify-write and clear-on-read merge.
module flow_acct_store
  import flow_acct_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int LEN_W  = 16,
  parameter int BYTE_W = 48,
  parameter int PKT_W  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_v,
  input  logic [FIDX_W-1:0] upd_flow,
  input  logic [LEN_W-1:0]  upd_len,
  input  logic [FIDX_W-1:0] rd_flow,
  input  logic              rd_take,
  input  logic              rd_clr,
  output logic [BYTE_W-1:0] rd_bytes,
  output logic [PKT_W-1:0]  rd_pkts
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [FIDX_W:0] DEPTH_L = (FIDX_W+1)'(DEPTH);

  logic [BYTE_W-1:0] byte_mem [DEPTH];
  logic [PKT_W-1:0]  pkt_mem  [DEPTH];

  logic              upd_hit, rd_hit, clr_go, same_entry;
  logic [AW-1:0]     ua, ra;
  logic [BYTE_W-1:0] cur_b, b_next, b_fresh;
  logic [PKT_W-1:0]  cur_p, p_next;
  logic [BYTE_W:0]   bsum;

  assign upd_hit    = upd_v && ({1'b0, upd_flow} < DEPTH_L);
  assign rd_hit     = {1'b0, rd_flow} < DEPTH_L;
  assign ua         = upd_flow[AW-1:0];
  assign ra         = rd_flow[AW-1:0];
  assign clr_go     = rd_take && rd_clr && rd_hit;
  assign same_entry = upd_hit && (ua == ra);

  assign cur_b   = byte_mem[ua];
  assign cur_p   = pkt_mem[ua];
  assign bsum    = {1'b0, cur_b} + (BYTE_W+1)'(upd_len);
  assign b_next  = bsum[BYTE_W] ? {BYTE_W{1'b1}} : bsum[BYTE_W-1:0];
  assign p_next  = (&cur_p) ? cur_p : cur_p + 1'b1;
  assign b_fresh = BYTE_W'(upd_len);

  assign rd_bytes = rd_hit ? byte_mem[ra] : '0;
  assign rd_pkts  = rd_hit ? pkt_mem[ra]  : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        byte_mem[i] <= '0;
        pkt_mem[i]  <= '0;
      end
    end else begin
      if (upd_hit) begin
        byte_mem[ua] <= b_next;
        pkt_mem[ua]  <= p_next;
      end
      if (clr_go) begin
        if (same_entry) begin
          byte_mem[ra] <= b_fresh;
          pkt_mem[ra]  <= PKT_W'(1);
        end else begin
          byte_mem[ra] <= '0;
          pkt_mem[ra]  <= '0;
        end
      end
    end
  end

  // Tracking state for the checks below.
  logic          trk_merge_v, trk_full_v;
  logic [AW-1:0] trk_merge_i, trk_full_i;
  logic [LEN_W-1:0] trk_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      trk_merge_v <= 1'b0;
      trk_full_v  <= 1'b0;
      trk_merge_i <= '0;
      trk_full_i  <= '0;
      trk_len     <= '0;
    end else begin
      trk_merge_v <= clr_go && same_entry;
      trk_merge_i <= ra;
      trk_len     <= upd_len;
      trk_full_v  <= upd_hit && (&cur_p) && !(clr_go && same_entry);
      trk_full_i  <= ua;
    end
  end

  // R8: a colliding clear keeps the report that hit the same entry
  a_r8_merge_keeps_update: assert property (@(posedge clk) disable iff (rst)
    trk_merge_v |-> (byte_mem[trk_merge_i] == BYTE_W'(trk_len)) &&
                    (pkt_mem[trk_merge_i] == PKT_W'(1)));

  // R10: a full packet counter stays full after another report
  a_r10_pkt_no_wrap: assert property (@(posedge clk) disable iff (rst)
    trk_full_v |-> (&pkt_mem[trk_full_i]));

endmodule

// File: rtl/flow_acct_reader.sv
// Indirect read sequencer: start/busy handshake and result capture.
module flow_acct_reader
  import flow_acct_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int BYTE_W = 48,
  parameter int PKT_W  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [31:0]       cmd_wdata,
  input  logic [BYTE_W-1:0] rd_bytes,
  input  logic [PKT_W-1:0]  rd_pkts,
  output logic              busy,
  output logic [FIDX_W-1:0] rd_flow,
  output res_words_t        res
);

  localparam logic [FIDX_W:0] DEPTH_L = (FIDX_W+1)'(DEPTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      rd_flow <= '0;
      res     <= '0;
    end else if (busy) begin
      busy <= 1'b0;
      res  <= pack_result(BYTE_FIELD_W'(rd_bytes), PKT_FIELD_W'(rd_pkts));
    end else if (cmd_we && cmd_wdata[CMD_GO_BIT]) begin
      busy    <= 1'b1;
      rd_flow <= cmd_wdata[FIDX_W-1:0];
    end
  end

  // R4: busy lasts a single cycle
  a_r4_busy_single: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);

  // R11: the index of a read in progress cannot be replaced
  a_r11_idx_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(rd_flow));

  // R9: out-of-range reads yield zero words
  a_r9_oor_zero: assert property (@(posedge clk) disable iff (rst)
    (busy && ({1'b0, rd_flow} >= DEPTH_L)) |=> (res == '0));

endmodule

// File: rtl/flow_acct_csr.sv
// Register decode: config, command strobe, registered read mux.
module flow_acct_csr
  import flow_acct_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              busy,
  input  logic [FIDX_W-1:0] rd_flow,
  input  res_words_t        res,
  output logic              cfg_en,
  output logic              cfg_clr,
  output logic              cmd_we,
  output logic [31:0]       cmd_wdata,
  output logic [31:0]       bus_rdata
);

  logic [31:0] cmd_view, cfg_view;

  assign cmd_we    = bus_we && (bus_addr == OFS_CMD);
  assign cmd_wdata = bus_wdata;

  always_comb begin
    cmd_view = '0;
    cmd_view[CMD_GO_BIT]   = busy;
    cmd_view[FIDX_W-1:0]   = rd_flow;
    cfg_view = '0;
    cfg_view[CFG_EN_BIT]   = cfg_en;
    cfg_view[CFG_RCLR_BIT] = cfg_clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_en  <= 1'b0;
      cfg_clr <= 1'b0;
    end else if (bus_we && (bus_addr == OFS_CFG)) begin
      cfg_en  <= bus_wdata[CFG_EN_BIT];
      cfg_clr <= bus_wdata[CFG_RCLR_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      case (bus_addr)
        OFS_CFG:  bus_rdata <= cfg_view;
        OFS_CMD:  bus_rdata <= cmd_view;
        OFS_RES0: bus_rdata <= res.w0;
        OFS_RES1: bus_rdata <= res.w1;
        OFS_RES2: bus_rdata <= res.w2;
        default:  bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/flow_acct_table.sv
module flow_acct_table
  import flow_acct_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int LEN_W  = 16,
  parameter int BYTE_W = 48,
  parameter int PKT_W  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_valid,
  input  logic [FIDX_W-1:0] cnt_flow,
  input  logic [LEN_W-1:0]  cnt_len,
  input  logic [31:0]       cnt_info,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  logic              cfg_en, cfg_clr, cmd_we, busy, upd_v;
  logic [31:0]       cmd_wdata;
  logic [FIDX_W-1:0] upd_flow, rd_flow;
  logic [LEN_W-1:0]  upd_len;
  logic [BYTE_W-1:0] rd_bytes;
  logic [PKT_W-1:0]  rd_pkts;
  res_words_t        res;

  flow_acct_ingress #(.LEN_W(LEN_W)) u_ingress (
    .clk(clk), .rst(rst), .cfg_en(cfg_en),
    .in_valid(cnt_valid), .in_flow(cnt_flow), .in_len(cnt_len), .in_info(cnt_info),
    .upd_v(upd_v), .upd_flow(upd_flow), .upd_len(upd_len)
  );

  flow_acct_store #(.DEPTH(DEPTH), .LEN_W(LEN_W), .BYTE_W(BYTE_W), .PKT_W(PKT_W)) u_store (
    .clk(clk), .rst(rst),
    .upd_v(upd_v), .upd_flow(upd_flow), .upd_len(upd_len),
    .rd_flow(rd_flow), .rd_take(busy), .rd_clr(cfg_clr),
    .rd_bytes(rd_bytes), .rd_pkts(rd_pkts)
  );

  flow_acct_reader #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .PKT_W(PKT_W)) u_reader (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .rd_bytes(rd_bytes), .rd_pkts(rd_pkts),
    .busy(busy), .rd_flow(rd_flow), .res(res)
  );

  flow_acct_csr u_csr (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .busy(busy), .rd_flow(rd_flow), .res(res),
    .cfg_en(cfg_en), .cfg_clr(cfg_clr), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .bus_rdata(bus_rdata)
  );

endmodule

// File: tb/flow_acct_table_test.sv
module flow_acct_table_test;
  import flow_acct_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_valid = 1'b0;
  logic [13:0] cnt_flow = '0;
  logic [15:0] cnt_len = '0;
  logic [31:0] cnt_info = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_main, rdata_sat;
  logic        use_sat = 1'b0;
  int          n_cmp = 0, n_bad = 0;

  localparam logic [31:0] FLAG   = 32'h0000_8000;
  localparam logic [31:0] NOFLAG = 32'hFFFF_7FFF;

  always #4 clk = ~clk;

  flow_acct_table uut (
    .clk(clk), .rst(rst), .cnt_valid(cnt_valid), .cnt_flow(cnt_flow),
    .cnt_len(cnt_len), .cnt_info(cnt_info), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_main)
  );

  flow_acct_table #(.DEPTH(64), .LEN_W(16), .BYTE_W(20), .PKT_W(8)) uut_sat (
    .clk(clk), .rst(rst), .cnt_valid(cnt_valid), .cnt_flow(cnt_flow),
    .cnt_len(cnt_len), .cnt_info(cnt_info), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_sat)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = use_sat ? rdata_sat : rdata_main;
  endtask

  task automatic count(input int f, input int len, input logic [31:0] info);
    cnt_valid = 1'b1; cnt_flow = 14'(f); cnt_len = 16'(len); cnt_info = info;
    @(negedge clk);
    cnt_valid = 1'b0;
  endtask

  task automatic burst(input int f, input int len, input int n);
    cnt_valid = 1'b1; cnt_flow = 14'(f); cnt_len = 16'(len); cnt_info = FLAG;
    repeat (n) @(negedge clk);
    cnt_valid = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    int polls = 0;
    do begin
      bus_read(OFS_CMD, v);
      polls++;
    end while (v[16] && polls < 8);
    if (v[16]) chk({tag, " R4 busy never cleared"}, 64'(v[16]), 64'd0);
  endtask

  task automatic collect(output logic [31:0] w0, w1, w2);
    bus_read(OFS_RES0, w0);
    bus_read(OFS_RES1, w1);
    bus_read(OFS_RES2, w2);
  endtask

  task automatic read_entry(input string tag, input int f,
                            output logic [63:0] bytes, output logic [63:0] pkts,
                            output logic [31:0] w2);
    logic [31:0] w0, w1;
    bus_write(OFS_CMD, 32'h0001_0000 | 32'(f));
    wait_idle(tag);
    collect(w0, w1, w2);
    bytes = {16'h0, w1[15:0], w0};
    pkts  = {24'h0, w2[23:0], w1[31:16]};
  endtask

  task automatic t_reset();
    logic [63:0] b, p; logic [31:0] w2, v;
    bus_read(OFS_CFG, v);  chk("R1 config after reset", 64'(v), 0);
    bus_read(OFS_CMD, v);  chk("R1 command after reset", 64'(v), 0);
    bus_read(OFS_RES0, v); chk("R1 result0 after reset", 64'(v), 0);
    read_entry("R1", 5, b, p, w2);
    chk("R1 bytes after reset", b, 0);
    chk("R1 packets after reset", p, 0);
  endtask

  task automatic t_config();
    logic [31:0] v;
    bus_write(OFS_CFG, 32'h3);
    bus_read(OFS_CFG, v); chk("R12 config readback 3", 64'(v), 64'h3);
    bus_write(OFS_CFG, 32'h1);
    bus_read(OFS_CFG, v); chk("R12 config readback 1", 64'(v), 64'h1);
  endtask

  task automatic t_count();
    logic [63:0] b, p; logic [31:0] w2;
    cnt_valid = 1'b1; cnt_info = FLAG;
    cnt_flow = 14'd3; cnt_len = 16'd100; @(negedge clk);
    cnt_flow = 14'd3; cnt_len = 16'd200; @(negedge clk);
    cnt_flow = 14'd4; cnt_len = 16'd7;   @(negedge clk);
    cnt_flow = 14'd3; cnt_len = 16'd300; @(negedge clk);
    cnt_valid = 1'b0;
    read_entry("R2", 3, b, p, w2);
    chk("R2 entry 3 bytes", b, 600);
    chk("R2 entry 3 packets", p, 3);
    read_entry("R2", 4, b, p, w2);
    chk("R2 entry 4 bytes", b, 7);
    chk("R2 entry 4 packets", p, 1);
  endtask

  task automatic t_drop();
    logic [63:0] b, p; logic [31:0] w2;
    count(7, 55, NOFLAG);
    read_entry("R3", 7, b, p, w2);
    chk("R3 unflagged report bytes", b, 0);
    chk("R3 unflagged report packets", p, 0);
    bus_write(OFS_CFG, 32'h0);
    count(8, 66, FLAG);
    bus_write(OFS_CFG, 32'h1);
    read_entry("R3", 8, b, p, w2);
    chk("R3 disabled report bytes", b, 0);
    chk("R3 disabled report packets", p, 0);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    bus_write(OFS_CMD, 32'h0001_0003);
    bus_read(OFS_CMD, v); chk("R4 busy right after start", 64'(v[16]), 1);
    bus_read(OFS_CMD, v); chk("R4 busy cleared next cycle", 64'(v[16]), 0);
  endtask

  task automatic t_noclear();
    logic [63:0] b, p; logic [31:0] w2;
    read_entry("R6", 3, b, p, w2);
    chk("R6 first read bytes", b, 600);
    read_entry("R6", 3, b, p, w2);
    chk("R6 second read bytes", b, 600);
    chk("R6 second read packets", p, 3);
  endtask

  task automatic t_pack();
    logic [31:0] w0, w1, w2;
    burst(9, 65535, 65540);
    bus_write(OFS_CMD, 32'h0001_0009);
    wait_idle("R5");
    collect(w0, w1, w2);
    chk("R5 result word 0", 64'(w0), 64'd196604);
    chk("R5 result word 1", 64'(w1), 64'h0004_0001);
    chk("R5 result word 2", 64'(w2), 64'h1);
  endtask

  task automatic t_ignore();
    logic [63:0] b, p; logic [31:0] w0, w1, w2, v;
    bus_we = 1'b1; bus_addr = OFS_CMD; bus_wdata = 32'h0001_0004;
    @(negedge clk);
    bus_wdata = 32'h0001_000B;
    @(negedge clk);
    bus_we = 1'b0;
    wait_idle("R11");
    bus_read(OFS_CMD, v); chk("R11 index kept", 64'(v), 64'h4);
    collect(w0, w1, w2);
    b = {16'h0, w1[15:0], w0}; p = {24'h0, w2[23:0], w1[31:16]};
    chk("R11 bytes of first index", b, 7);
    chk("R11 packets of first index", p, 1);
  endtask

  task automatic t_sat();
    logic [63:0] b, p; logic [31:0] w0, w1, w2;
    burst(2, 4095, 300);
    use_sat = 1'b1;
    bus_write(OFS_CMD, 32'h0001_0002);
    wait_idle("R10");
    collect(w0, w1, w2);
    use_sat = 1'b0;
    chk("R10 saturated bytes", 64'(w0), 64'hFFFFF);
    chk("R10 saturated packets", 64'(w1), 64'h00FF_0000);
    chk("R10 saturated word 2", 64'(w2), 0);
    read_entry("R10", 2, b, p, w2);
    chk("R10 wide bytes", b, 1228500);
    chk("R10 wide packets", p, 300);
  endtask

  task automatic t_clear();
    logic [63:0] b, p; logic [31:0] w2;
    bus_write(OFS_CFG, 32'h3);
    read_entry("R7", 3, b, p, w2);
    chk("R7 clearing read bytes", b, 600);
    chk("R7 clearing read packets", p, 3);
    read_entry("R7", 3, b, p, w2);
    chk("R7 bytes after clear", b, 0);
    chk("R7 packets after clear", p, 0);
  endtask

  task automatic t_collide();
    logic [63:0] b, p; logic [31:0] w0, w1, w2;
    count(10, 50, FLAG);
    cnt_valid = 1'b1; cnt_flow = 14'd10; cnt_len = 16'd70; cnt_info = FLAG;
    bus_we = 1'b1; bus_addr = OFS_CMD; bus_wdata = 32'h0001_000A;
    @(negedge clk);
    cnt_valid = 1'b0; bus_we = 1'b0;
    wait_idle("R8");
    collect(w0, w1, w2);
    b = {16'h0, w1[15:0], w0}; p = {24'h0, w2[23:0], w1[31:16]};
    chk("R8 read returns prior bytes", b, 50);
    chk("R8 read returns prior packets", p, 1);
    read_entry("R8", 10, b, p, w2);
    chk("R8 colliding report kept bytes", b, 70);
    chk("R8 colliding report kept packets", p, 1);
  endtask

  task automatic t_range();
    logic [63:0] b, p; logic [31:0] w2;
    count(64, 123, FLAG);
    read_entry("R9", 0, b, p, w2);
    chk("R9 entry 0 untouched bytes", b, 0);
    chk("R9 entry 0 untouched packets", p, 0);
    read_entry("R9", 64, b, p, w2);
    chk("R9 read at depth bytes", b, 0);
    read_entry("R9", 16383, b, p, w2);
    chk("R9 read at top index packets", p, 0);
    chk("R9 read at top index word 2", 64'(w2), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_config();
    t_count();
    t_drop();
    t_busy();
    t_noclear();
    t_pack();
    t_ignore();
    t_sat();
    t_clear();
    t_collide();
    t_range();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule